// File: doc/BRIEF.md
# Overlapping 1011 Pattern Detector

This block watches a single serial bit that is sampled on every rising clock edge. It raises a one-cycle detect flag each time the four most recent samples, oldest first, read 1, 0, 1, 1. Matches may overlap. When one match completes, its trailing bits can serve as the start of the next one. For example, the stream 1011011 yields two flags, three cycles apart.

The controller is a Moore machine with one flip-flop per state. It has five states: an idle state and four progress states. Each state flop is fed by its own OR-of-products next-state equation. The detect flag is taken straight from the flop for the final progress state, so it is glitch-free and changes only on a clock edge. The full state vector is brought out for observation. A companion flag goes high whenever that vector does not hold exactly one set bit.

Top module: `seq1011_detector`

## Requirements
- R1: Reset is synchronous and active-low. On every rising edge with `rst_n` low, the state vector becomes 5'b00001 and `match_o` goes low. The state bit order is: bit0 idle (nothing matched), bit1 "1 seen", bit2 "10 seen", bit3 "101 seen", bit4 "1011 seen".
- R2: Out of reset, `state_o` holds exactly one set bit at all times. `onehot_err_o` is high exactly when `state_o` does not hold one set bit, so on a correct design it never rises.
- R3: `match_o` is high for the clock cycle that follows the rising edge at which the final 1 of a 1011 run was sampled. It is low in every other cycle, and it always equals bit4 of `state_o`.
- R4: Detection overlaps. The stream 1011011 produces two flags three cycles apart. The stream 10111011 produces two flags four cycles apart.
- R5: From the "1011 seen" state, a sampled 1 moves to "1 seen" and a sampled 0 moves to "10 seen".
- R6: From idle, a sampled 0 stays in idle. From "10 seen", a sampled 0 returns to idle.
- R7: `match_o` is never high in two consecutive cycles.
- R8: `match_o` is low throughout reset and after the first rising edge following reset release.
- R9: From "1 seen", a sampled 1 stays in "1 seen". From "101 seen", a sampled 0 moves to "10 seen". Together with R5 and R6, the state after each edge encodes the longest suffix of the sampled stream that is a prefix of 1011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `bit_in` is sampled here |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data bit, already synchronous to `clk` |
| match_o | output | 1 | One-cycle pulse after 1011 completes |
| state_o | output | 5 | One-hot state vector (bit0 idle ... bit4 pattern complete) |
| onehot_err_o | output | 1 | High when `state_o` is not exactly one-hot |

## Verification
The embedded properties assume that `bit_in` is synchronous to `clk` and settled at each rising edge. They also assume that reset is held low for at least one edge before checking begins, because the one-hot and transition properties are disabled while `rst_n` is low. The stimulus changes `bit_in` and `rst_n` only on falling edges. It opens with several reset edges and later reasserts reset mid-pattern. Beyond that, it feeds directed overlap streams and a long pseudo-random stream, so every transition of every state is taken at least once.

// File: rtl/seqdet_pkg.sv
// Package: shared constants for the one-hot 1011 detector.
// Assumes a fixed five-state machine; bit positions define the state
// order that the next-state equations and the checker rely on.
package seqdet_pkg;

    localparam int ST_N = 5;

    localparam int IX_NONE = 0;  // nothing of the pattern seen
    localparam int IX_1    = 1;  // "1" seen
    localparam int IX_10   = 2;  // "10" seen
    localparam int IX_101  = 3;  // "101" seen
    localparam int IX_HIT  = 4;  // "1011" seen, detect state

    typedef logic [ST_N-1:0] state_vec_t;

    localparam state_vec_t RESET_VEC = state_vec_t'(1) << IX_NONE;

endpackage

// File: rtl/seqdet_next.sv
// Module: next-state network of the one-hot 1011 detector.
// One OR-of-products term group per state flop; relies on the current
// vector being one-hot, so no complemented state literals are needed.
module seqdet_next
    import seqdet_pkg::*;
(
    input  state_vec_t cur_i,
    input  logic       bit_i,
    output state_vec_t nxt_o
);

    // Purpose: form each flop's D input from the states that lead into it.
    always_comb begin
        nxt_o          = '0;
        nxt_o[IX_NONE] = (cur_i[IX_NONE] & ~bit_i) | (cur_i[IX_10] & ~bit_i);
        nxt_o[IX_1]    = (cur_i[IX_NONE] &  bit_i) | (cur_i[IX_1] & bit_i)
                       | (cur_i[IX_HIT]  &  bit_i);
        nxt_o[IX_10]   = (cur_i[IX_1]    & ~bit_i) | (cur_i[IX_101] & ~bit_i)
                       | (cur_i[IX_HIT]  & ~bit_i);
        nxt_o[IX_101]  =  cur_i[IX_10]   &  bit_i;
        nxt_o[IX_HIT]  =  cur_i[IX_101]  &  bit_i;
    end

endmodule

// File: rtl/seqdet_state_reg.sv
// Module: bank of state flops, one per state.
// Each flop loads its own reset value synchronously while rst_n is low;
// the reset vector selects which flop presets and which clear.
module seqdet_state_reg #(
    parameter int           W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar gi = 0; gi < W; gi++) begin : g_flop
        // Purpose: one state flop with synchronous preset or clear.
        always_ff @(posedge clk) begin
            if (!rst_n) q_o[gi] <= RST_VAL[gi];
            else        q_o[gi] <= d_i[gi];
        end
    end

endmodule

// File: rtl/seqdet_onehot_chk.sv
// Module: population check on the state vector.
// Flags any vector with zero or several set bits; purely combinational.
module seqdet_onehot_chk #(
    parameter int W = 5
) (
    input  logic [W-1:0] vec_i,
    output logic         bad_o
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] ones;

    // Purpose: count set bits and compare against one.
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) ones = ones + CW'(vec_i[i]);
        bad_o = (ones != CW'(1));
    end

endmodule

// File: rtl/seq1011_detector.sv
// Module: overlapping 1011 serial pattern detector (Moore, one-hot).
// Assumes bit_in is synchronous to clk. Detect output is the final
// state flop itself, so it only changes on a clock edge.
module seq1011_detector
    import seqdet_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_in,
    output logic            match_o,
    output logic [ST_N-1:0] state_o,
    output logic            onehot_err_o
);

    state_vec_t cur_q;
    state_vec_t nxt_d;

    seqdet_next u_next (
        .cur_i (cur_q),
        .bit_i (bit_in),
        .nxt_o (nxt_d)
    );

    seqdet_state_reg #(
        .W       (ST_N),
        .RST_VAL (RESET_VEC)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (nxt_d),
        .q_o   (cur_q)
    );

    seqdet_onehot_chk #(
        .W (ST_N)
    ) u_chk (
        .vec_i (cur_q),
        .bad_o (onehot_err_o)
    );

    assign match_o = cur_q[IX_HIT];
    assign state_o = cur_q;

    // R1: a reset edge leaves the idle vector.
    p_reset_vec_r1: assert property (@(posedge clk)
        !rst_n |=> (state_o == RESET_VEC));

    // R2: one-hot out of reset, and the checker agrees.
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(state_o) == 1) && !onehot_err_o);

    // R3: the last 1 of 101+1 raises the detect flag.
    p_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[IX_101] && bit_in |=> match_o);

    // R5: exits from the detect state.
    p_hit_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[IX_HIT] && bit_in |=> state_o[IX_1]);
    p_hit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[IX_HIT] && !bit_in |=> state_o[IX_10]);

    // R6: zeros park the machine in idle.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o[IX_NONE] || state_o[IX_10]) && !bit_in |=> state_o[IX_NONE]);

    // R7: no back-to-back detections.
    p_no_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    // R8: detect is low just after a reset edge.
    p_quiet_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !match_o);

endmodule

// File: tb/seq1011_detector_tb_top.sv
// Bench: behavioural reference (sample history queue) compared each cycle.
module seq1011_detector_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_in;
    logic       match_o;
    logic [4:0] state_o;
    logic       onehot_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit prev_match = 0;
    bit hist[$];
    int hit_cycles[$];

    always #10 clk = ~clk;  // 50 MHz

    seq1011_detector dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .match_o      (match_o),
        .state_o      (state_o),
        .onehot_err_o (onehot_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Longest suffix of history that is a prefix of 1,0,1,1.
    function automatic int progress();
        bit pat[4] = '{1'b1, 1'b0, 1'b1, 1'b1};
        for (int k = 4; k > 0; k--) begin
            if (hist.size() >= k) begin
                bit ok = 1;
                for (int j = 0; j < k; j++)
                    if (hist[hist.size() - k + j] != pat[j]) ok = 0;
                if (ok) return k;
            end
        end
        return 0;
    endfunction

    task automatic step(input bit b, input string req);
        int p;
        bit_in = b;
        @(posedge clk);
        cyc++;
        hist.push_back(b);
        if (hist.size() > 4) void'(hist.pop_front());
        @(negedge clk);
        p = progress();
        check(state_o == (5'b1 << p), req, state_o, 5'b1 << p);
        check(match_o == (p == 4), "R3", match_o, (p == 4));
        check(!(match_o && prev_match), "R7", match_o, 0);
        check(!onehot_err_o, "R2", onehot_err_o, 0);
        if (match_o) hit_cycles.push_back(cyc);
        prev_match = match_o;
    endtask

    task automatic do_reset(input int edges);
        rst_n = 1'b0;
        repeat (edges) begin
            @(posedge clk);
            @(negedge clk);
            check(state_o == 5'b00001, "R1", state_o, 1);
            check(!match_o, "R8", match_o, 0);
        end
        hist.delete();
        prev_match = 0;
        rst_n = 1'b1;
    endtask

    task automatic run_overlap(input bit bits[], input int gap, input string req);
        hit_cycles.delete();
        foreach (bits[i]) step(bits[i], req);
        check(hit_cycles.size() == 2, req, hit_cycles.size(), 2);
        if (hit_cycles.size() == 2)
            check(hit_cycles[1] - hit_cycles[0] == gap, req,
                  hit_cycles[1] - hit_cycles[0], gap);
        repeat (4) step(1'b0, "R6");
    endtask

    initial begin
        #4ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit_in = 1'b0;
        @(negedge clk);
        do_reset(3);
        // R8: first edge after release, even with a 1 applied
        step(1'b1, "R8");
        check(!match_o, "R8", match_o, 0);
        // R6: idle holds on zeros; 10 then 0 returns to idle
        step(1'b0, "R6");
        step(1'b0, "R6");
        step(1'b0, "R6");
        // R9: 1 then 1 stays in "1 seen"; 101 then 0 goes to "10 seen"
        step(1'b1, "R9"); step(1'b1, "R9");
        step(1'b0, "R9"); step(1'b1, "R9"); step(1'b0, "R9");
        // R5: detect then 0 -> "10 seen"
        step(1'b1, "R5"); step(1'b1, "R5"); step(1'b0, "R5");
        repeat (3) step(1'b0, "R6");
        // R4: overlapping streams
        run_overlap('{1,0,1,1,0,1,1}, 3, "R4");
        run_overlap('{1,0,1,1,1,0,1,1}, 4, "R4");
        // R5: detect then 1 -> "1 seen"
        step(1'b1, "R5"); step(1'b0, "R5"); step(1'b1, "R5");
        step(1'b1, "R5"); step(1'b1, "R5");
        // R1: reset mid-pattern
        step(1'b0, "R1"); step(1'b1, "R1");
        do_reset(1);
        step(1'b1, "R8");
        // Random stream
        for (int i = 0; i < 2000; i++) step(1'($urandom_range(0, 1)), "R9");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule